// File: doc/BRIEF.md
# Output Rounding, Saturation and Format Stage

This block sits at the end of a filter datapath. It takes the wide signed accumulator result and turns it into a 16-bit output bus. A 3-bit rounding code sets how many of the 16 bus bits carry data, from 8 to 16. The value is rounded half-up at the least significant kept bit. It is then saturated to the range of the kept width and encoded as two's complement, inverted offset binary or unsigned.

Bus bits at and below the rounding point are released: their drive enable is low. The whole bus is released while the active-low output enable is high. Data and per-bit drive enables are registered on an update strobe. The output enable gates the drive vector combinationally, with no clock involved.

The accumulator carries `GUARD` fraction bits below output bit 0. With rounding code 0 and no saturation, the bus value equals the accumulator shifted right by `GUARD` and rounded. The upper twelve bus bits therefore line up in weight with a 12-bit input sample.

Top module: `obus_shaper`

## Requirements
- R1: The rounding code c gives d dropped bits: d = c for c = 0..6 and d = 8 for c = 7. After an update with the output enable low, `bus_drive` bits [15:d] are 1 and bits below d are 0. Code 0 drives all 16 bits, including bit 0.
- R2: With s = GUARD + d, the kept value is floor((acc + 2^(s-1)) / 2^s), with no half added when s = 0. Ties round toward plus infinity.
- R3: With w = 16 - d, the rounded value is clamped to [-2^(w-1), 2^(w-1)-1] before encoding.
- R4: When `fmt_twos` is 1, bits [15:d] hold the clamped value as a w-bit two's complement field.
- R5: When `fmt_twos` is 0, `fmt_qual` is 1 and the code is nonzero, bits [15:d] hold the clamped value with negative values replaced by 0, so bit 15 is 0.
- R6: When `fmt_twos` is 0 and either `fmt_qual` is 0 or the code is 0, bits [15:d] hold the w-bit two's complement field with every bit except bit 15 inverted.
- R7: While `oe_n` is 1, `bus_drive` is all zeros at once, without waiting for a clock edge. When `oe_n` returns to 0, the registered enables reappear.
- R8: `bus_data` and `bus_drive` change only on a clock edge where `upd_stb` is 1. Input changes while it is 0 have no effect.
- R9: Synchronous active-high reset clears `bus_data` and the registered drive enables to 0.
- R10: `bus_data` bits below d are 0 after every update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_stb | input | 1 | Output update strobe |
| acc_in | input | ACC_W | Signed accumulator result, GUARD fraction bits below bus bit 0 |
| rnd_code | input | 3 | Rounding position code |
| fmt_twos | input | 1 | 1 selects two's complement output |
| fmt_qual | input | 1 | With fmt_twos low and a nonzero code, 1 selects unsigned |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_data | output | 16 | Registered output data |
| bus_drive | output | 16 | Per-bit drive enable, 1 means driven |

## Verification
A wrong shift amount or rounding constant appears as an off-by-one or misplaced value on `bus_data` in the cycle after the update strobe. It is most visible on tie values and on inputs just inside the saturation limits. A wrong width decode shows the same cycle as a misshapen `bus_drive` vector or as nonzero bits below the rounding point. A format or clamp fault shows as a wrong code at the extremes. Because every update fully replaces the registers, no error persists past the next strobe. The sweeps therefore cover every code and format pairing, and probe the tie and limit inputs for each width.

// File: rtl/obus_pkg.sv
package obus_pkg;

    localparam int unsigned OUT_W  = 16;
    localparam int unsigned CODE_W = 3;

    typedef enum logic [1:0] {
        FMT_TWOS    = 2'd0,
        FMT_OFF_INV = 2'd1,
        FMT_UNSIGN  = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic [OUT_W-1:0] drive;
    } obus_word_t;

    // number of bus bits released below the kept field
    function automatic int unsigned drop_bits(input logic [CODE_W-1:0] code);
        int unsigned d;
        case (code)
            3'd7:    d = 8;
            default: d = int'(code);
        endcase
        return d;
    endfunction

    function automatic fmt_e pick_fmt(input logic twos, input logic qual,
                                      input logic [CODE_W-1:0] code);
        fmt_e f;
        if (twos)
            f = FMT_TWOS;
        else if (qual && (code != '0))
            f = FMT_UNSIGN;
        else
            f = FMT_OFF_INV;
        return f;
    endfunction

endpackage

// File: rtl/obus_round.sv
module obus_round
    import obus_pkg::*;
#(
    parameter int unsigned ACC_W = 22,
    parameter int unsigned GUARD = 2,
    localparam int unsigned SUM_W = ACC_W + 1
) (
    input  logic signed [ACC_W-1:0]  acc,
    input  logic        [CODE_W-1:0] code,
    output logic signed [SUM_W-1:0]  kept
);

    int unsigned              sh;
    logic signed [SUM_W-1:0]  ext;
    logic signed [SUM_W-1:0]  half;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        sh   = GUARD + drop_bits(code);
        ext  = {acc[ACC_W-1], acc};
        half = (sh == 0) ? '0 : (SUM_W'(1) << (sh - 1));
        sum  = ext + half;
        kept = sum >>> sh;
    end

endmodule

// File: rtl/obus_limit.sv
module obus_limit
    import obus_pkg::*;
#(
    parameter int unsigned VAL_W = 23
) (
    input  logic signed [VAL_W-1:0]  val,
    input  logic        [CODE_W-1:0] code,
    output logic signed [OUT_W-1:0]  lim
);

    int unsigned             w;
    logic signed [VAL_W-1:0] maxv;
    logic signed [VAL_W-1:0] minv;
    logic signed [VAL_W-1:0] clip;

    always_comb begin
        w    = OUT_W - drop_bits(code);
        maxv = (VAL_W'(1) << (w - 1)) - VAL_W'(1);
        minv = -maxv - VAL_W'(1);
        if (val > maxv)
            clip = maxv;
        else if (val < minv)
            clip = minv;
        else
            clip = val;
        lim = clip[OUT_W-1:0];
    end

endmodule

// File: rtl/obus_format.sv
module obus_format
    import obus_pkg::*;
(
    input  logic signed [OUT_W-1:0]  lim,
    input  logic        [CODE_W-1:0] code,
    input  logic                     twos,
    input  logic                     qual,
    output obus_word_t               word
);

    int unsigned      drop;
    logic [OUT_W-1:0] mask;
    logic [OUT_W-1:0] placed;
    fmt_e             fsel;

    assign drop = drop_bits(code);

    for (genvar gi = 0; gi < OUT_W; gi++) begin : g_mask
        assign mask[gi] = (32'(gi) >= drop);
    end

    always_comb begin
        fsel   = pick_fmt(twos, qual, code);
        placed = lim << drop;
        case (fsel)
            FMT_UNSIGN:  word.data = lim[OUT_W-1] ? '0 : placed;
            FMT_OFF_INV: word.data = placed ^ ({1'b0, {(OUT_W-1){1'b1}}} & mask);
            default:     word.data = placed;
        endcase
        word.drive = mask;
    end

endmodule

// File: rtl/obus_shaper.sv
module obus_shaper
    import obus_pkg::*;
#(
    parameter int unsigned ACC_W = 22,
    parameter int unsigned GUARD = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd_stb,
    input  logic [ACC_W-1:0]         acc_in,
    input  logic [2:0]               rnd_code,
    input  logic                     fmt_twos,
    input  logic                     fmt_qual,
    input  logic                     oe_n,
    output logic [15:0]              bus_data,
    output logic [15:0]              bus_drive
);

    localparam int unsigned VAL_W = ACC_W + 1;

    logic signed [VAL_W-1:0] kept;
    logic signed [OUT_W-1:0] lim;
    obus_word_t              nxt;
    obus_word_t              cur;

    obus_round #(.ACC_W(ACC_W), .GUARD(GUARD)) round_i (
        .acc  (acc_in),
        .code (rnd_code),
        .kept (kept)
    );

    obus_limit #(.VAL_W(VAL_W)) limit_i (
        .val  (kept),
        .code (rnd_code),
        .lim  (lim)
    );

    obus_format format_i (
        .lim  (lim),
        .code (rnd_code),
        .twos (fmt_twos),
        .qual (fmt_qual),
        .word (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (upd_stb)
            cur <= nxt;
    end

    assign bus_data  = cur.data;
    assign bus_drive = oe_n ? '0 : cur.drive;

    // R1: kept field is a contiguous run of enables from bit 15 downward
    assert_drive_shape_R1: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> cur.drive[15] && ((~cur.drive & (~cur.drive + 16'd1)) == 16'd0));

    // R5: unsigned encoding never sets the top bit
    assert_unsigned_pos_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && !fmt_twos && fmt_qual && (rnd_code != 3'd0)) |=> !cur.data[15]);

    // R7: output enable high releases every bit
    assert_oe_release_R7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (bus_drive == 16'd0));

    // R8: no strobe, no change
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |=> ($stable(cur.data) && $stable(cur.drive)));

    // R9: reset clears the registers
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> ((cur.data == 16'd0) && (cur.drive == 16'd0)));

    // R10: released bits carry no data
    assert_low_zero_R10: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> ((cur.data & ~cur.drive) == 16'd0));

endmodule

// File: tb/obus_shaper_tb.sv
`timescale 1ns/1ps
module obus_shaper_tb_top;

    localparam int ACC_W = 22;
    localparam int GUARD = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd_stb = 1'b0;
    logic [ACC_W-1:0] acc_in = '0;
    logic [2:0]       rnd_code = 3'd0;
    logic             fmt_twos = 1'b1;
    logic             fmt_qual = 1'b0;
    logic             oe_n = 1'b0;
    logic [15:0]      bus_data;
    logic [15:0]      bus_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    obus_shaper #(.ACC_W(ACC_W), .GUARD(GUARD)) dut_i (
        .clk (clk), .rst (rst), .upd_stb (upd_stb), .acc_in (acc_in),
        .rnd_code (rnd_code), .fmt_twos (fmt_twos), .fmt_qual (fmt_qual),
        .oe_n (oe_n), .bus_data (bus_data), .bus_drive (bus_drive)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int drop_of(input int code);
        return (code == 7) ? 8 : code;
    endfunction

    function automatic logic [15:0] exp_drive(input int code);
        return 16'(16'hFFFF << drop_of(code));
    endfunction

    function automatic logic [15:0] exp_data(input longint a, input int code,
                                             input bit tc, input bit q, output bit sat);
        int     d  = drop_of(code);
        int     w  = 16 - d;
        int     sh = GUARD + d;
        longint hi = (longint'(1) << (w - 1)) - 1;
        longint lo = -(longint'(1) << (w - 1));
        longint md = longint'(1) << w;
        longint v;
        longint f;
        v = a + ((sh > 0) ? (longint'(1) << (sh - 1)) : 0);
        v = v >>> sh;
        sat = 0;
        if (v > hi) begin v = hi; sat = 1; end
        if (v < lo) begin v = lo; sat = 1; end
        if (tc)
            f = (v + md) % md;
        else if (q && code != 0)
            f = (v < 0) ? 0 : v;
        else
            f = ((v + md) % md) ^ (hi);
        return 16'(f << d);
    endfunction

    task automatic apply(input longint a, input int code, input bit tc, input bit q);
        logic [15:0] e;
        bit          sat;
        string       tag;
        @(negedge clk);
        acc_in   = ACC_W'(a);
        rnd_code = 3'(code);
        fmt_twos = tc;
        fmt_qual = q;
        upd_stb  = 1'b1;
        @(negedge clk);
        upd_stb  = 1'b0;
        e = exp_data(a, code, tc, q, sat);
        if (sat)                   tag = "R3 saturate";
        else if (tc)               tag = "R2/R4 twos";
        else if (q && code != 0)   tag = "R5 unsigned";
        else                       tag = "R6 offset-inverted";
        check(tag, bus_data, e);
        check("R1 drive", bus_drive, exp_drive(code));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] held_d;
        logic [15:0] held_e;
        longint      amin = -(longint'(1) << (ACC_W - 1));
        longint      amax = (longint'(1) << (ACC_W - 1)) - 1;
        repeat (3) @(negedge clk);
        check("R9 reset data", bus_data, 16'h0000);
        check("R9 reset drive", bus_drive, 16'h0000);
        rst = 1'b0;

        // sweep every code and format pair over the accumulator range
        for (int code = 0; code < 8; code++) begin
            for (int fm = 0; fm < 4; fm++) begin
                for (longint a = amin; a <= amax; a += 8191)
                    apply(a, code, fm[0], fm[1]);
            end
        end

        // tie and limit probes per width
        for (int code = 0; code < 8; code++) begin
            int     sh   = GUARD + drop_of(code);
            int     w    = 16 - drop_of(code);
            longint half = longint'(1) << (sh - 1);
            longint top  = ((longint'(1) << (w - 1)) - 1) << sh;
            longint bot  = -(longint'(1) << (w - 1)) << sh;
            longint pts [12] = '{half, -half, half - 1, -half - 1,
                                 top + half - 1, top + half, top - half,
                                 bot - half, bot - half - 1, bot,
                                 amax, amin};
            for (int fm = 0; fm < 4; fm++) begin
                foreach (pts[k]) apply(pts[k], code, fm[0], fm[1]);
            end
        end

        // R10: released bits zero with every bit of the input set
        apply(-1, 7, 1'b1, 1'b0);
        check("R10 low bits", bus_data & ~exp_drive(7), 16'h0000);

        // R8: no strobe, inputs move, outputs stay
        apply(40000, 3, 1'b1, 1'b0);
        held_d = bus_data;
        held_e = bus_drive;
        @(negedge clk);
        acc_in   = ACC_W'(-123456);
        rnd_code = 3'd7;
        fmt_twos = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 hold data", bus_data, held_d);
        check("R8 hold drive", bus_drive, held_e);

        // R7: asynchronous release, between edges
        #1 oe_n = 1'b1;
        #1 check("R7 oe release", bus_drive, 16'h0000);
        #1 oe_n = 1'b0;
        #1 check("R7 oe restore", bus_drive, held_e);

        // R9: reset clears after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset data again", bus_data, 16'h0000);
        check("R9 reset drive again", bus_drive, 16'h0000);

        finish_run();
    end

endmodule